// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader with Offset-QPSK I/Q Split

This block turns a stream of 4-bit data symbols into the chip streams that feed an offset-QPSK modulator with half-sine pulse shaping. Each accepted nibble selects one of sixteen nearly orthogonal 32-chip spreading codes. The 32 chips are then sent out one per chip period, with a chip period of `CLK_PER_CHIP` clocks. For a 2 Mchip/s chip rate on a 250 MHz clock this is 125 clocks, so one symbol takes 16 µs.

Chips with an even index drive the in-phase (I) stream and chips with an odd index drive the quadrature (Q) stream. Every I or Q chip is held for two chip periods, and Q starts one chip period later than I. The result is a constant-envelope, MSK-equivalent waveform once each held chip is shaped by a half-sine. For each stream the block reports an active flag, the chip polarity (1 means +1, 0 means -1) and a sample index that runs across the half-sine. A downstream shaper or DAC feeder can use that index to address a sine table.

Upstream logic presents symbols one at a time on a valid/ready interface. When bytes are being spread, the low nibble goes first. The block has no DAC, no filtering and no frame or preamble generation.

Top module: `dsss_oqpsk_spreader`

## Requirements
- R1: After a synchronous active-high reset, `chip_stb`, `i_act`, `i_bit`, `i_smp`, `q_act`, `q_bit` and `q_smp` are all 0 and `sym_ready` is 1.
- R2: Chip n of symbol 0 is bit n of 32'h744AC39B, and chip 0 is sent first.
- R3: For symbols k = 1..7, chip n equals chip (n - 4k) mod 32 of symbol 0. Each of these codes is symbol 0 rotated later by 4k chip positions.
- R4: For symbols 8..15, chip n equals chip n of symbol (k - 8), inverted when n is odd.
- R5: `chip_stb` pulses for one clock at the start of every chip period, exactly `CLK_PER_CHIP` clocks apart within and across back-to-back symbols, and 32 times per symbol. The first pulse is visible in the second clock after the handshake edge.
- R6: Even chips appear on I and odd chips on Q, each held for two chip periods. A Q chip begins one chip period after the I chip before it.
- R7: While a stream is active, its sample index starts at 0 on the clock its chip begins and rises by 1 each clock up to 2*`CLK_PER_CHIP`-1.
- R8: `sym_ready` is high when the block is fully idle. While a symbol is being sent, it is high only during the final clock of chip 31.
- R9: When a symbol is accepted on the final clock of the previous one, chips continue with no gap. Q keeps carrying the previous symbol's chip 31 through chip period 0 of the new symbol.
- R10: With no symbol waiting, `chip_stb` stays low and I goes idle at once. Q completes the second half of chip 31 and then goes idle. Idle means act, bit and sample are all 0.
- R11: A reset in the middle of a symbol abandons it and returns the outputs to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 4 | Symbol value 0..15 |
| sym_ready | output | 1 | Symbol accepted on this clock when valid |
| chip_stb | output | 1 | Start-of-chip-period pulse |
| i_act | output | 1 | I stream carries a pulse |
| i_bit | output | 1 | I chip polarity (1 = +1) |
| i_smp | output | $clog2(2*CLK_PER_CHIP) | I half-sine sample index |
| q_act | output | 1 | Q stream carries a pulse |
| q_bit | output | 1 | Q chip polarity (1 = +1) |
| q_smp | output | $clog2(2*CLK_PER_CHIP) | Q half-sine sample index |

## Verification
The bench targets the seam between symbols. A design that reloads the chip register too early would put the new symbol's chip on Q during period 0 where the old chip 31 belongs, and a design that drops the Q tail when traffic stops would cut the last half-sine in two. It sends every one of the sixteen codes, so a wrong rotation direction or an inversion applied to even chips shows up as a wrong polarity on one stream. It also checks that ready never opens in the middle of a symbol, that no stray strobe appears while idle, and that a reset in the middle of a symbol leaves nothing half-driven.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int SYM_W      = 4;
  localparam int N_SYMS     = 1 << SYM_W;
  localparam int CHIPS      = 32;
  localparam int CHIP_IDX_W = $clog2(CHIPS);
  localparam int ROT_STEP   = 4;

  typedef logic [CHIPS-1:0] chip_word_t;

  // bit n is chip n of code 0
  localparam chip_word_t BASE_CODE = 32'h744AC39B;

  function automatic chip_word_t spread_code(input logic [SYM_W-1:0] sym);
    chip_word_t w;
    int rot;
    rot = int'(sym[SYM_W-2:0]) * ROT_STEP;
    for (int n = 0; n < CHIPS; n++) begin
      w[n] = BASE_CODE[(n + CHIPS - rot) % CHIPS] ^ (sym[SYM_W-1] & ((n % 2) == 1));
    end
    return w;
  endfunction
endpackage

// File: rtl/dsss_chip_rom.sv
module dsss_chip_rom
  import dsss_pkg::*;
#(
  parameter int DEPTH = N_SYMS
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output chip_word_t               rd_data
);
  chip_word_t table_w [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_fill
    assign table_w[s] = spread_code(SYM_W'(s));
  end

  // registered read so the table maps onto a block RAM
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= table_w[rd_addr];
  end
endmodule

// File: rtl/dsss_chip_seq.sv
module dsss_chip_seq
  import dsss_pkg::*;
#(
  parameter int CLK_PER_CHIP = 125
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sym_valid,
  output logic                  sym_ready,
  output logic                  load,
  output logic                  run,
  output logic                  tail,
  output logic [CHIP_IDX_W-1:0] chip_n,
  output logic [$clog2(CLK_PER_CHIP)-1:0] phase,
  output logic                  last_ph
);
  localparam int PH_W = $clog2(CLK_PER_CHIP);
  localparam logic [PH_W-1:0]       PH_LAST   = PH_W'(CLK_PER_CHIP - 1);
  localparam logic [CHIP_IDX_W-1:0] CHIP_LAST = CHIP_IDX_W'(CHIPS - 1);

  logic busy;

  assign busy      = run | tail;
  assign last_ph   = (phase == PH_LAST);
  assign sym_ready = ~busy | (last_ph & (run ? (chip_n == CHIP_LAST) : 1'b1));
  assign load      = sym_valid & sym_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      tail   <= 1'b0;
      chip_n <= '0;
      phase  <= '0;
    end else begin
      // Q pulse started in an odd period spills into the next period
      if (run && last_ph && chip_n[0]) tail <= 1'b1;
      else if (last_ph)                tail <= 1'b0;

      if (load) begin
        run    <= 1'b1;
        chip_n <= '0;
        phase  <= '0;
      end else if (busy) begin
        if (last_ph) begin
          phase <= '0;
          if (run) begin
            if (chip_n == CHIP_LAST) begin
              run    <= 1'b0;
              chip_n <= '0;
            end else begin
              chip_n <= chip_n + 1'b1;
            end
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsss_iq_split.sv
module dsss_iq_split
  import dsss_pkg::*;
#(
  parameter int CLK_PER_CHIP = 125
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  tail,
  input  logic                  last_ph,
  input  logic [CHIP_IDX_W-1:0] chip_n,
  input  logic [$clog2(CLK_PER_CHIP)-1:0] phase,
  input  chip_word_t            word,
  output logic                  chip_stb,
  output logic                  i_act,
  output logic                  i_bit,
  output logic [$clog2(2*CLK_PER_CHIP)-1:0] i_smp,
  output logic                  q_act,
  output logic                  q_bit,
  output logic [$clog2(2*CLK_PER_CHIP)-1:0] q_smp
);
  localparam int SMP_W = $clog2(2*CLK_PER_CHIP);

  logic [SMP_W-1:0]      first_half;
  logic [SMP_W-1:0]      second_half;
  logic [CHIP_IDX_W-1:0] even_idx;
  logic                  q_hold;

  assign first_half  = SMP_W'(phase);
  assign second_half = SMP_W'(CLK_PER_CHIP) + SMP_W'(phase);
  assign even_idx    = {chip_n[CHIP_IDX_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_stb <= 1'b0;
      i_act    <= 1'b0;
      i_bit    <= 1'b0;
      i_smp    <= '0;
      q_act    <= 1'b0;
      q_bit    <= 1'b0;
      q_smp    <= '0;
      q_hold   <= 1'b0;
    end else begin
      chip_stb <= run && (phase == '0);

      if (run) begin
        i_act <= 1'b1;
        i_bit <= word[even_idx];
        i_smp <= chip_n[0] ? second_half : first_half;
      end else begin
        i_act <= 1'b0;
        i_bit <= 1'b0;
        i_smp <= '0;
      end

      // keep the odd chip so it survives a reload of the code word
      if (run && chip_n[0] && last_ph) q_hold <= word[chip_n];

      if (run && chip_n[0]) begin
        q_act <= 1'b1;
        q_bit <= word[chip_n];
        q_smp <= first_half;
      end else if (tail) begin
        q_act <= 1'b1;
        q_bit <= q_hold;
        q_smp <= second_half;
      end else begin
        q_act <= 1'b0;
        q_bit <= 1'b0;
        q_smp <= '0;
      end
    end
  end
endmodule

// File: rtl/dsss_oqpsk_spreader.sv
module dsss_oqpsk_spreader
  import dsss_pkg::*;
#(
  parameter int CLK_PER_CHIP = 125,
  localparam int SMP_W = $clog2(2*CLK_PER_CHIP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [3:0]       sym_data,
  output logic             sym_ready,
  output logic             chip_stb,
  output logic             i_act,
  output logic             i_bit,
  output logic [SMP_W-1:0] i_smp,
  output logic             q_act,
  output logic             q_bit,
  output logic [SMP_W-1:0] q_smp
);
  localparam int PH_W = $clog2(CLK_PER_CHIP);

  logic                  load;
  logic                  run;
  logic                  tail;
  logic                  last_ph;
  logic [CHIP_IDX_W-1:0] chip_n;
  logic [PH_W-1:0]       phase;
  chip_word_t            word;

  dsss_chip_seq #(.CLK_PER_CHIP(CLK_PER_CHIP)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .load      (load),
    .run       (run),
    .tail      (tail),
    .chip_n    (chip_n),
    .phase     (phase),
    .last_ph   (last_ph)
  );

  dsss_chip_rom #(.DEPTH(N_SYMS)) u_rom (
    .clk     (clk),
    .rd_en   (load),
    .rd_addr (sym_data),
    .rd_data (word)
  );

  dsss_iq_split #(.CLK_PER_CHIP(CLK_PER_CHIP)) u_split (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tail     (tail),
    .last_ph  (last_ph),
    .chip_n   (chip_n),
    .phase    (phase),
    .word     (word),
    .chip_stb (chip_stb),
    .i_act    (i_act),
    .i_bit    (i_bit),
    .i_smp    (i_smp),
    .q_act    (q_act),
    .q_bit    (q_bit),
    .q_smp    (q_smp)
  );
endmodule

// File: rtl/dsss_oqpsk_spreader_chk.sv
module dsss_oqpsk_spreader_chk #(
  parameter int CLK_PER_CHIP = 125,
  localparam int SMP_W = $clog2(2*CLK_PER_CHIP)
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [3:0]       sym_data,
  input logic             sym_ready,
  input logic             chip_stb,
  input logic             i_act,
  input logic             i_bit,
  input logic [SMP_W-1:0] i_smp,
  input logic             q_act,
  input logic             q_bit,
  input logic [SMP_W-1:0] q_smp
);
  int   gap;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (chip_stb) begin
      gap  <= 0;
      seen <= 1'b1;
    end else if (gap < CLK_PER_CHIP) begin
      gap <= gap + 1;
    end
  end

  p_stb_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (chip_stb && seen) |-> (gap >= CLK_PER_CHIP - 1));

  p_first_chip_r5: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ready) |=> ##1 chip_stb);

  p_q_offset_r6: assert property (@(posedge clk) disable iff (rst)
    (q_act && q_smp == '0) |-> (i_act && i_smp == SMP_W'(CLK_PER_CHIP)));

  p_smp_step_r7: assert property (@(posedge clk) disable iff (rst)
    (i_act && i_smp != '0) |-> ($past(i_act) && i_smp == $past(i_smp) + 1'b1));

  p_ready_closed_r8: assert property (@(posedge clk) disable iff (rst)
    ((CLK_PER_CHIP > 2) && chip_stb) |-> !sym_ready);

  p_q_tail_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(i_act)) |-> (q_act && q_smp == SMP_W'(CLK_PER_CHIP) && !chip_stb));
endmodule

bind dsss_oqpsk_spreader dsss_oqpsk_spreader_chk #(.CLK_PER_CHIP(CLK_PER_CHIP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sym_valid (sym_valid),
  .sym_data  (sym_data),
  .sym_ready (sym_ready),
  .chip_stb  (chip_stb),
  .i_act     (i_act),
  .i_bit     (i_bit),
  .i_smp     (i_smp),
  .q_act     (q_act),
  .q_bit     (q_bit),
  .q_smp     (q_smp)
);

// File: tb/tb_dsss_oqpsk_spreader.sv
module tb_dsss_oqpsk_spreader;
  localparam int CPC   = 4;
  localparam int SMP_W = $clog2(2*CPC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [3:0] sym_data = '0;
  logic sym_ready, chip_stb, i_act, i_bit, q_act, q_bit;
  logic [SMP_W-1:0] i_smp, q_smp;

  dsss_oqpsk_spreader #(.CLK_PER_CHIP(CPC)) dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .chip_stb(chip_stb),
    .i_act(i_act), .i_bit(i_bit), .i_smp(i_smp),
    .q_act(q_act), .q_bit(q_bit), .q_smp(q_smp)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic       cur;
    logic       prev;
    logic       pv;
    int         n;
    logic [3:0] sym;
    int         hs;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    last_stb = 0;
  bit    mon_en = 1'b0;
  logic  last_c31 = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // symbol k: base code rotated later by 4k chips, odd chips inverted for k >= 8
  function automatic logic ref_chip(input logic [3:0] s, input int n);
    logic [31:0] base = 32'h744AC39B;
    int src = (n - 4 * int'(s[2:0]) + 64) % 32;
    return base[src] ^ (s[3] && (n % 2 == 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] s, input bit cont);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_data  = s;
    while (!sym_ready) @(negedge clk);
    for (int n = 0; n < 32; n++) begin
      item_t it;
      it.cur  = ref_chip(s, n);
      it.prev = (n == 0) ? last_c31 : ref_chip(s, n - 1);
      it.pv   = (n != 0) || cont;
      it.n    = n;
      it.sym  = s;
      it.hs   = cyc + 1;
      exp_q.push_back(it);
    end
    last_c31 = ref_chip(s, 31);
    @(posedge clk);
  endtask

  task automatic check_idle();
    @(negedge clk);
    sym_valid = 1'b0;
    do begin
      @(negedge clk);
      #1;
    end while (exp_q.size() != 0);
    repeat (CPC) @(negedge clk);
    #1;
    chk(q_act && q_bit == last_c31 && q_smp == SMP_W'(CPC) && !i_act && !chip_stb,
        "R10", "q tail act/bit/smp", {q_act, q_bit, 4'(q_smp)}, {1'b1, last_c31, 4'(CPC)});
    repeat (CPC) @(negedge clk);
    #1;
    chk(!q_act && !q_bit && q_smp == '0 && !i_act && !i_bit && i_smp == '0,
        "R10", "idle outputs", {q_act, i_act, q_bit, i_bit}, 0);
    repeat (3 * CPC) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mon_en && chip_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "strobe with nothing queued", 1, 0);
      end else begin
        item_t it;
        string tag;
        it  = exp_q.pop_front();
        tag = (it.sym == 0) ? "R2" : (it.sym < 8) ? "R3" : "R4";
        chk(!sym_ready, "R8", "ready mid symbol", sym_ready, 0);
        if (it.n == 0) chk(cyc == it.hs + 1, "R5", "first strobe cycle", cyc, it.hs + 1);
        else           chk(cyc - last_stb == CPC, "R5", "strobe spacing", cyc - last_stb, CPC);
        last_stb = cyc;
        if (it.n % 2 == 1) begin
          chk(q_act && q_bit == it.cur, tag, $sformatf("q chip %0d sym %0d", it.n, it.sym), q_bit, it.cur);
          chk(q_smp == '0, "R7", "q sample start", q_smp, 0);
          chk(i_act && i_bit == it.prev && i_smp == SMP_W'(CPC), "R6", "i held second half",
              {i_bit, 4'(i_smp)}, {it.prev, 4'(CPC)});
        end else begin
          chk(i_act && i_bit == it.cur, tag, $sformatf("i chip %0d sym %0d", it.n, it.sym), i_bit, it.cur);
          chk(i_smp == '0, "R7", "i sample start", i_smp, 0);
          if (it.pv)
            chk(q_act && q_bit == it.prev && q_smp == SMP_W'(CPC), (it.n == 0) ? "R9" : "R6",
                "q held second half", {q_bit, 4'(q_smp)}, {it.prev, 4'(CPC)});
          else
            chk(!q_act, "R9", "q idle before first odd chip", q_act, 0);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!chip_stb && !i_act && !i_bit && i_smp == '0 && !q_act && !q_bit && q_smp == '0 && sym_ready,
            "R1", "reset state", {chip_stb, i_act, q_act, sym_ready}, 1);
        rst = 1'b0;
        mon_en = 1'b1;
        // all sixteen codes back to back
        for (int s = 0; s < 16; s++) send(4'(s), s != 0);
        check_idle();
        // isolated symbol
        send(4'd5, 1'b0);
        check_idle();
        // short burst across the inverted group
        send(4'd15, 1'b0);
        send(4'd8, 1'b1);
        send(4'd0, 1'b1);
        check_idle();
        // reset in the middle of a symbol
        send(4'd11, 1'b0);
        @(negedge clk);
        sym_valid = 1'b0;
        repeat (40) @(negedge clk);
        mon_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        chk(!chip_stb && !i_act && !q_act && i_smp == '0 && q_smp == '0 && sym_ready,
            "R11", "idle after mid-symbol reset", {chip_stb, i_act, q_act, sym_ready}, 1);
        repeat (2 * CPC) @(negedge clk);
        chk(!chip_stb && !i_act && !q_act, "R11", "still idle", {chip_stb, i_act, q_act}, 0);
        mon_en = 1'b1;
        send(4'd9, 1'b0);
        check_idle();
      end
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule